// File: doc/BRIEF.md
# Remote-Terminal Control Register with Error-Clear Sequencing

This block is the main control register of a serial-bus message processor that is working as a remote terminal. A host writes it with a write strobe, an address and a 16-bit data word, and reads it back with a read strobe. The block turns the stored fields into the control signals the rest of the chip uses:

- the operating-mode code, with each mode bit OR'ed with an external pin;
- an effective register address, OR'ed with the external address pins;
- a clock-frequency select and a no-response time-out select;
- one transmit enable for each of the two buses, gated by the external inhibit pins;
- a data-word inhibit flag;
- a one-cycle master-reset pulse, produced by software or by a pin.

The block also owns the ERROR output. An internal pulse sets it. It clears in one of three ways: on master reset, on a low-to-high write of the error-reset bit, or on its own after a fixed delay while that bit is held high. The delay is counted in clock cycles and scaled by the clock-select bit, so it lasts 4 µs at either clock rate. Master reset clears the rest of the chip but leaves this register as it was.

Top module: `term_ctrl_reg`

## Requirements
- R1: A write with `host_wr` high and `host_addr[2]`=1 stores all 16 data bits. A read with `host_rd` high at address 4'b1100 returns the stored bits, not the pin-OR'ed values. A read at any other address returns 0. After reset the register is 0.
- R2: `eff_addr` equals register bits [10:7] OR'ed with `pin_addr`, so a field value of 0000 lets the pins alone choose the address.
- R3: `op_mode` = {bit3 | `pin_mode_rt`, bit2 | `pin_mode_bc`}. The codes are: 00 monitor with an assigned terminal address, 01 bus controller, 10 remote terminal, 11 monitor without an address.
- R4: Bit 4 enables bus A and bit 5 enables bus B. `tx_en_a` is high only when bit 4 is 1, bit 5 is 0 and `pin_txinh_a` is low. `tx_en_b` follows the mirrored rule. When both bits are set, neither bus is enabled.
- R5: `clk_sel_12m` follows bit 13 (1 = 12 MHz, 0 = 24 MHz). `long_timeout` follows bit 14 (1 = about 131 µs gap, 0 = about 17 µs gap).
- R6: A write that changes bit 1 from 1 to 0 raises `mr_pulse` for exactly the one cycle after that write. `pin_mr` also drives `mr_pulse`. Master reset does not change the register.
- R7: An `err_set` pulse sets `error_out`. While bit 6 (error reset) is 0, `error_out` stays set until master reset clears it.
- R8: A write that changes bit 6 from 0 to 1 clears `error_out` at that write.
- R9: While bit 6 is 1, a newly set `error_out` stays high for exactly 48 cycles when bit 13 = 1, or 96 cycles when bit 13 = 0, and then clears.
- R10: `inhibit_data` follows bit 0. While bit 0 is 1, `err_set` is ignored and `error_out` stays low.
- R11: Master reset takes priority over `err_set` in the same cycle, and the error is left cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data (0 unless the control register is addressed) |
| pin_mode_bc | input | 1 | External bus-controller mode pin |
| pin_mode_rt | input | 1 | External remote-terminal mode pin |
| pin_addr | input | 4 | External register-address pins |
| pin_txinh_a | input | 1 | Transmit inhibit, bus A |
| pin_txinh_b | input | 1 | Transmit inhibit, bus B |
| pin_mr | input | 1 | External master-reset pin |
| err_set | input | 1 | Error-set pulse from the protocol engine |
| op_mode | output | 2 | Operating-mode code |
| eff_addr | output | 4 | Effective register address |
| clk_sel_12m | output | 1 | Clock select (1 = 12 MHz) |
| long_timeout | output | 1 | No-response time-out select (1 = long) |
| tx_en_a | output | 1 | Transmit enable, bus A |
| tx_en_b | output | 1 | Transmit enable, bus B |
| inhibit_data | output | 1 | Data-word transmission inhibit |
| mr_pulse | output | 1 | Master-reset pulse to the rest of the chip |
| error_out | output | 1 | ERROR output |

## Verification
The assertions assume that `err_set` comes from a protocol engine that raises it only between host writes. They also assume that `pin_mr` is low whenever a new error is expected to hold. A master reset in the same cycle as a set is allowed, and R11 covers it. The random phase keeps `err_set` and `pin_mr` low, so the error state stays still while write decoding, read-back and field decoding are exercised. Error sequencing is driven only in directed runs, where each set, clear and auto-clear count is placed at a known cycle.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int CTRL_W   = 16;
  localparam int RA_W     = 4;

  // Field positions inside the control word
  localparam int B_IDWT   = 0;
  localparam int B_MR     = 1;
  localparam int B_BC     = 2;
  localparam int B_RT     = 3;
  localparam int B_TXA    = 4;
  localparam int B_TXB    = 5;
  localparam int B_RERR   = 6;
  localparam int B_RA_LO  = 7;
  localparam int B_RA_HI  = B_RA_LO + RA_W - 1;
  localparam int B_CLK    = 13;
  localparam int B_TMO    = 14;

  typedef enum logic [1:0] {
    MODE_MON_ADDR   = 2'b00,
    MODE_BC         = 2'b01,
    MODE_RT         = 2'b10,
    MODE_MON_NOADDR = 2'b11
  } op_mode_e;
endpackage

// File: rtl/tcr_rst_sync.sv
module tcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tcr_regfile.sv
module tcr_regfile
  import tcr_pkg::*;
#(
  parameter logic [RA_W-1:0] RD_ADDR    = 4'b1100,
  parameter int              WR_SEL_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [RA_W-1:0]   host_addr,
  input  logic [CTRL_W-1:0] host_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W-1:0] host_rdata,
  output logic              mr_sw_pulse,
  output logic              rerr_rise
);
  logic              wr_hit;
  logic [CTRL_W-1:0] ctrl_d;
  logic              mr_fall_d;
  logic              mr_q;

  always_comb begin
    wr_hit    = host_wr & host_addr[WR_SEL_BIT];
    ctrl_d    = wr_hit ? host_wdata : ctrl_q;
    mr_fall_d = wr_hit & ctrl_q[B_MR] & ~host_wdata[B_MR];
    rerr_rise = wr_hit & ~ctrl_q[B_RERR] & host_wdata[B_RERR];
    host_rdata = (host_rd && host_addr == RD_ADDR) ? ctrl_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mr_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      mr_q   <= mr_fall_d;
    end
  end

  assign mr_sw_pulse = mr_q;

  // R6: the software reset pulse never lasts two cycles
  a_r6_mr_single: assert property (@(posedge clk) disable iff (!rst_n)
    mr_q |=> !mr_q);

  // R1 / R6: without a write hit the register keeps its value (master reset included)
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr[WR_SEL_BIT]) |=> $stable(ctrl_q));
endmodule

// File: rtl/tcr_decode.sv
module tcr_decode
  import tcr_pkg::*;
(
  input  logic            f_bc,
  input  logic            f_rt,
  input  logic            f_txa,
  input  logic            f_txb,
  input  logic [RA_W-1:0] f_ra,
  input  logic            pin_mode_bc,
  input  logic            pin_mode_rt,
  input  logic [RA_W-1:0] pin_addr,
  input  logic            pin_txinh_a,
  input  logic            pin_txinh_b,
  output op_mode_e        op_mode,
  output logic [RA_W-1:0] eff_addr,
  output logic            tx_en_a,
  output logic            tx_en_b
);
  always_comb begin
    op_mode  = op_mode_e'({f_rt | pin_mode_rt, f_bc | pin_mode_bc});
    eff_addr = f_ra | pin_addr;
    tx_en_a  = f_txa & ~f_txb & ~pin_txinh_a;
    tx_en_b  = f_txb & ~f_txa & ~pin_txinh_b;
  end
endmodule

// File: rtl/tcr_err_ctrl.sv
module tcr_err_ctrl #(
  parameter int LIM_12M = 48,
  parameter int LIM_24M = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_set,
  input  logic inhibit,
  input  logic rerr_lvl,
  input  logic rerr_rise,
  input  logic mr,
  input  logic clk12,
  output logic error_q
);
  localparam int LIM_MAX = (LIM_12M > LIM_24M) ? LIM_12M : LIM_24M;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);
  localparam logic [CNT_W-1:0] LAST_12M = CNT_W'(LIM_12M - 1);
  localparam logic [CNT_W-1:0] LAST_24M = CNT_W'(LIM_24M - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             err_d;
  logic             set_ok;

  always_comb begin
    last   = clk12 ? LAST_12M : LAST_24M;
    set_ok = err_set & ~inhibit;
    err_d  = error_q;
    cnt_d  = cnt_q;
    if (mr) begin
      err_d = 1'b0;
      cnt_d = '0;
    end else if (set_ok) begin
      err_d = 1'b1;
      cnt_d = '0;
    end else if (rerr_rise) begin
      err_d = 1'b0;
      cnt_d = '0;
    end else if (error_q && rerr_lvl) begin
      if (cnt_q >= last) begin
        err_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      error_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      error_q <= err_d;
      cnt_q   <= cnt_d;
    end
  end

  // R6 / R11: master reset always leaves the error cleared
  a_r11_mr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mr |=> !error_q);

  // R7: an accepted set with no reset raises the error
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set && !inhibit && !mr) |=> error_q);

  // R7: with the reset bit low the error only falls on master reset or a reset-bit rise
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (error_q && !rerr_lvl && !rerr_rise && !mr) |=> error_q);

  // R10: with inhibit set, a cleared error stays cleared
  a_r10_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (!error_q && inhibit) |=> !error_q);

  // R9: the auto-clear counter stays inside the longest window
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(LIM_MAX));
endmodule

// File: rtl/term_ctrl_reg.sv
module term_ctrl_reg
  import tcr_pkg::*;
#(
  parameter int AUTOCLR_12M = 48,
  parameter int AUTOCLR_24M = 96
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [3:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        pin_mode_bc,
  input  logic        pin_mode_rt,
  input  logic [3:0]  pin_addr,
  input  logic        pin_txinh_a,
  input  logic        pin_txinh_b,
  input  logic        pin_mr,
  input  logic        err_set,
  output logic [1:0]  op_mode,
  output logic [3:0]  eff_addr,
  output logic        clk_sel_12m,
  output logic        long_timeout,
  output logic        tx_en_a,
  output logic        tx_en_b,
  output logic        inhibit_data,
  output logic        mr_pulse,
  output logic        error_out
);
  logic              rst_sync_n;
  logic [CTRL_W-1:0] ctrl_q;
  logic              mr_sw_pulse;
  logic              rerr_rise;
  op_mode_e          mode_e;

  tcr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tcr_regfile u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .ctrl_q      (ctrl_q),
    .host_rdata  (host_rdata),
    .mr_sw_pulse (mr_sw_pulse),
    .rerr_rise   (rerr_rise)
  );

  tcr_decode u_dec (
    .f_bc        (ctrl_q[B_BC]),
    .f_rt        (ctrl_q[B_RT]),
    .f_txa       (ctrl_q[B_TXA]),
    .f_txb       (ctrl_q[B_TXB]),
    .f_ra        (ctrl_q[B_RA_HI:B_RA_LO]),
    .pin_mode_bc (pin_mode_bc),
    .pin_mode_rt (pin_mode_rt),
    .pin_addr    (pin_addr),
    .pin_txinh_a (pin_txinh_a),
    .pin_txinh_b (pin_txinh_b),
    .op_mode     (mode_e),
    .eff_addr    (eff_addr),
    .tx_en_a     (tx_en_a),
    .tx_en_b     (tx_en_b)
  );

  always_comb begin
    op_mode      = mode_e;
    clk_sel_12m  = ctrl_q[B_CLK];
    long_timeout = ctrl_q[B_TMO];
    inhibit_data = ctrl_q[B_IDWT];
    mr_pulse     = mr_sw_pulse | pin_mr;
  end

  tcr_err_ctrl #(
    .LIM_12M (AUTOCLR_12M),
    .LIM_24M (AUTOCLR_24M)
  ) u_err (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .err_set   (err_set),
    .inhibit   (ctrl_q[B_IDWT]),
    .rerr_lvl  (ctrl_q[B_RERR]),
    .rerr_rise (rerr_rise),
    .mr        (mr_pulse),
    .clk12     (ctrl_q[B_CLK]),
    .error_q   (error_out)
  );

  // R4: the two bus enables are never active together
  a_r4_one_bus: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({tx_en_a, tx_en_b}));
endmodule

// File: tb/term_ctrl_reg_tb.sv
module term_ctrl_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_rd;
  logic [3:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        pin_mode_bc, pin_mode_rt;
  logic [3:0]  pin_addr;
  logic        pin_txinh_a, pin_txinh_b, pin_mr, err_set;
  logic [1:0]  op_mode;
  logic [3:0]  eff_addr;
  logic        clk_sel_12m, long_timeout, tx_en_a, tx_en_b;
  logic        inhibit_data, mr_pulse, error_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [15:0] model;

  always #4 clk = ~clk;

  term_ctrl_reg u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_mode(input logic [15:0] d, input logic rt, input logic bc);
    return {d[3] | rt, d[2] | bc};
  endfunction

  function automatic logic exp_tx(input logic mine, input logic other, input logic inh);
    return mine & ~other & ~inh;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    if (a[2]) model = d;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    host_rd = 1'b0;
  endtask

  task automatic pulse_err();
    @(negedge clk); err_set = 1'b1;
    @(negedge clk); err_set = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] rv;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
    pin_mode_bc = 0; pin_mode_rt = 0; pin_addr = 0; pin_txinh_a = 0;
    pin_txinh_b = 0; pin_mr = 0; err_set = 0; model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(4'b1100, rv);
    chk("R1 reset value", rv, 16'h0000);
    chk("R7 reset error", error_out, 0);
    chk("R6 reset mr_pulse", mr_pulse, 0);

    // Random phase: R1..R6, R10 decoding
    for (int i = 0; i < 80; i++) begin
      logic [15:0] d, old;
      logic [3:0] a;
      old = model;
      d = 16'($urandom);
      a = 4'($urandom);
      @(negedge clk);
      pin_mode_bc = 1'($urandom); pin_mode_rt = 1'($urandom);
      pin_addr = 4'($urandom) & {4{1'($urandom)}};
      pin_txinh_a = 1'($urandom); pin_txinh_b = 1'($urandom);
      wr(a, d);
      chk("R6 mr pulse after write", mr_pulse, a[2] & old[1] & ~d[1]);
      chk("R2 eff_addr", eff_addr, model[10:7] | pin_addr);
      chk("R3 op_mode", op_mode, exp_mode(model, pin_mode_rt, pin_mode_bc));
      chk("R4 tx_en_a", tx_en_a, exp_tx(model[4], model[5], pin_txinh_a));
      chk("R4 tx_en_b", tx_en_b, exp_tx(model[5], model[4], pin_txinh_b));
      chk("R5 clk_sel", clk_sel_12m, model[13]);
      chk("R5 timeout", long_timeout, model[14]);
      chk("R10 inhibit_data", inhibit_data, model[0]);
      rd(4'b1100, rv);
      chk("R1 readback", rv, model);
      a = 4'($urandom);
      if (a != 4'b1100) begin
        rd(a, rv);
        chk("R1 other read address", rv, 16'h0000);
      end
      @(negedge clk);
      chk("R6 mr pulse one cycle", mr_pulse, 0);
    end
    pin_mode_bc = 0; pin_mode_rt = 0; pin_addr = 0; pin_txinh_a = 0; pin_txinh_b = 0;

    // R2 corner: field 0000 leaves pins alone
    wr(4'b0100, 16'h0000);
    pin_addr = 4'b1010; #1;
    chk("R2 pins alone", eff_addr, 4'b1010);
    pin_addr = 0;
    // R4 corner: both bus bits -> neither bus
    wr(4'b1111, 16'h0030);
    chk("R4 both set a", tx_en_a, 0);
    chk("R4 both set b", tx_en_b, 0);

    // R7: error holds with reset bit low, cleared only by master reset
    wr(4'b0100, 16'h2000);
    pulse_err();
    chk("R7 error set", error_out, 1);
    repeat (150) @(negedge clk);
    chk("R7 error held", error_out, 1);
    pin_mr = 1'b1; #1;
    chk("R6 pin drives mr_pulse", mr_pulse, 1);
    @(negedge clk); pin_mr = 1'b0;
    chk("R7 cleared by master reset", error_out, 0);
    rd(4'b1100, rv);
    chk("R6 register survives master reset", rv, 16'h2000);

    // R6: software master reset via 1 then 0 clears error
    pulse_err();
    wr(4'b0100, 16'h2002);
    chk("R6 no pulse on setting bit", mr_pulse, 0);
    wr(4'b0100, 16'h2000);
    chk("R6 sw pulse", mr_pulse, 1);
    @(negedge clk);
    chk("R6 sw pulse ends", mr_pulse, 0);
    chk("R6 sw reset clears error", error_out, 0);

    // R8: reset-bit rise clears error
    pulse_err();
    chk("R8 error set", error_out, 1);
    wr(4'b0100, 16'h2040);
    chk("R8 rise clears", error_out, 0);

    // R9: auto-clear at 12 MHz setting -> 48 cycles
    pulse_err();
    repeat (47) @(negedge clk);
    chk("R9 still set at 47 (12MHz)", error_out, 1);
    @(negedge clk);
    chk("R9 cleared at 48 (12MHz)", error_out, 0);
    // R9: 24 MHz setting -> 96 cycles
    wr(4'b0100, 16'h0040);
    pulse_err();
    repeat (95) @(negedge clk);
    chk("R9 still set at 95 (24MHz)", error_out, 1);
    @(negedge clk);
    chk("R9 cleared at 96 (24MHz)", error_out, 0);

    // R10: inhibit blocks error set
    wr(4'b0100, 16'h0001);
    chk("R10 inhibit output", inhibit_data, 1);
    pulse_err();
    chk("R10 set ignored", error_out, 0);
    repeat (3) @(negedge clk);
    chk("R10 still low", error_out, 0);

    // R11: master reset wins over set in the same cycle
    wr(4'b0100, 16'h0000);
    @(negedge clk); err_set = 1'b1; pin_mr = 1'b1;
    @(negedge clk); err_set = 1'b0; pin_mr = 1'b0;
    chk("R11 reset beats set", error_out, 0);

    summary();
  end
endmodule